// File: doc/BRIEF.md
# Carry-Aware ALU and Shift Execute Stage

This block is the 32-bit execute stage of a small timer coprocessor. For each instruction it runs one arithmetic or logical operation and then an optional shift. It keeps two flags. The ALU flag is the carry produced by the operation. The shift flag is the carry left after the shift step. The shift flag is the carry that later add-with-carry and subtract-with-borrow instructions consume.

The first operand can come from the `opa` port or from a word in a single-port remote memory. The result can go to an internal result register, to the remote word, or to both. A remote write stores either the whole word or only the 9-bit pointer field in bits [8:0].

The stage stretches over one to three cycles. Each of the following adds one cycle, up to a total of three:
- a remote read,
- a remote write,
- a remote address that equals the next-instruction fetch address.

A `start` pulse launches an instruction. `done` marks its last cycle.

Top module: `alu_shift_exec`

## Requirements
- R1: The op field selects 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-borrow, 100 AND, 101 OR, 110 XOR, and the ALU result is the 32-bit outcome of that operation.
- R2: The ALU flag depends on the operation:
  - add and add-with-carry: the carry out of bit 31;
  - subtract and subtract-with-borrow: 1 when no borrow occurred;
  - AND, OR and XOR: cleared.
- R3: The shift mode field selects how the ALU result is shifted by `shamt` (0 to 31) bit positions:
  - 000: no shift;
  - 001: arithmetic right, with bit 31 copied into the vacated bits;
  - 010: logical left;
  - 011: left shift that fills the vacated low bits with the ALU flag;
  - 100: logical right;
  - 101: right shift that fills the vacated high bits with the ALU flag;
  - 110: rotate right;
  - 111: 33-bit rotate right through the flag, in which the flag enters bit 31.
- R4: When the shift is nonzero and the mode is not 000, the shift flag equals the last bit shifted out. When the shift is zero or the mode is 000, the data and the shift flag equal the ALU result and the ALU flag.
- R5: Add-with-carry adds the committed shift flag. Subtract-with-borrow subtracts the inverse of that flag.
- R6: An instruction lasts 1 + (remote read) + (remote write) + (`rem_addr` == `next_addr`) cycles, capped at 3. Cycle 1 is the cycle after the clock edge that accepts `start`.
- R7: When `src_rem` is 1, `mem_rd` is high in cycle 1 only, at `rem_addr`. The word returned one cycle later replaces `opa` as the first operand.
- R8: The `rdest` field selects 00 none, 01 full-word write and 10 pointer-only write. The write happens in the final cycle only:
  - `mem_wr` is high in that cycle;
  - `mem_wdata` carries the shifted result;
  - `mem_ptr_only` is 1 for the pointer-only write.
- R9: `done` is high for exactly the final cycle. The flags commit only at the end of that cycle. `result` updates only if `reg_wr` was 1 at start.
- R10: A `start` that arrives while `busy` is high is ignored. Input changes during execution do not alter the instruction in flight.
- R11: Synchronous reset clears `busy`, `done`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an instruction (accepted when idle) |
| op | input | 3 | ALU operation |
| shmode | input | 3 | Shift mode |
| shamt | input | 5 | Shift distance |
| src_rem | input | 1 | Take first operand from remote memory |
| reg_wr | input | 1 | Write result register |
| rdest | input | 2 | Remote destination selector |
| rem_addr | input | 9 | Remote word address |
| next_addr | input | 9 | Next-instruction fetch address |
| opa | input | 32 | First operand when not remote |
| opb | input | 32 | Second operand |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Final execution cycle |
| result | output | 32 | Result register |
| flag_alu | output | 1 | Carry after the ALU step |
| flag_shift | output | 1 | Carry after the shift step |
| mem_addr | output | 9 | Remote memory address |
| mem_rd | output | 1 | Remote read strobe |
| mem_wr | output | 1 | Remote write strobe |
| mem_ptr_only | output | 1 | Write only bits [8:0] |
| mem_wdata | output | 32 | Remote write data |
| mem_rdata | input | 32 | Remote read data, valid one cycle after `mem_rd` |

## Verification
Fixed cases cover every shift mode at distances 0, 1, 5 and 31, with the incoming flag both set and clear. Together they separate fill-with-flag from zero fill, and rotate from rotate-through-carry.

Add and subtract operands are chosen to straddle overflow and borrow. Chained add-with-carry and subtract-with-borrow then show that the committed shift flag, not the ALU flag, is consumed.

Every combination of remote read, remote write and address collision is run, to separate the 1, 2 and 3 cycle schedules. A pointer-only write uses a memory word with ones in its upper bits, so a full-word write would show.

A long pseudo-random stream then mixes all fields against the behavioural model.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

    localparam int DW  = 32;   // datapath width
    localparam int AW  = 9;    // remote word address width
    localparam int SAW = 5;    // shift distance width

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBB = 3'b011,
        OP_AND = 3'b100,
        OP_OR  = 3'b101,
        OP_XOR = 3'b110,
        OP_RSV = 3'b111
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_NONE = 3'b000,
        SH_ASR  = 3'b001,
        SH_LSL  = 3'b010,
        SH_CSL  = 3'b011,
        SH_LSR  = 3'b100,
        SH_CSR  = 3'b101,
        SH_ROR  = 3'b110,
        SH_CROR = 3'b111
    } shift_mode_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'b00,
        RD_FULL = 2'b01,
        RD_PTR  = 2'b10,
        RD_RSV  = 2'b11
    } rdest_e;

    typedef struct packed {
        alu_op_e         op;
        shift_mode_e     mode;
        logic [SAW-1:0]  amt;
        logic            src_rem;
        logic            reg_wr;
        rdest_e          rdest;
        logic [AW-1:0]   raddr;
        logic [DW-1:0]   a;
        logic [DW-1:0]   b;
    } instr_t;

    function automatic logic is_logic_op(alu_op_e o);
        return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
    endfunction

    function automatic logic writes_remote(rdest_e d);
        return (d == RD_FULL) || (d == RD_PTR);
    endfunction

    // one base cycle plus one per extra event, capped at three
    function automatic logic [1:0] exec_cycles(logic rd, logic wr, logic coll);
        logic [1:0] n;
        n = 2'(rd) + 2'(wr) + 2'(coll);
        return (n >= 2'd2) ? 2'd3 : n + 2'd1;
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_shift_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int XW = W + 1;

    logic [XW-1:0] sum;

    always_comb begin
        sum  = '0;
        res  = '0;
        cout = 1'b0;
        unique case (op)
            OP_ADD: sum = {1'b0, a} + {1'b0, b};
            OP_ADC: sum = {1'b0, a} + {1'b0, b} + XW'(cin);
            OP_SUB: sum = {1'b0, a} + {1'b0, ~b} + XW'(1);
            OP_SBB: sum = {1'b0, a} + {1'b0, ~b} + XW'(cin);
            OP_AND: sum = {1'b0, a & b};
            OP_OR:  sum = {1'b0, a | b};
            OP_XOR: sum = {1'b0, a ^ b};
            default: sum = {1'b0, a} + {1'b0, b};
        endcase
        res  = sum[W-1:0];
        cout = is_logic_op(op) ? 1'b0 : sum[W];
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import alu_shift_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  shift_mode_e    mode,
    input  logic [SW-1:0]  amt,
    input  logic [W-1:0]   din,
    input  logic           cin,
    output logic [W-1:0]   dout,
    output logic           cout
);
    localparam int XW = W + 1;

    logic [SW-1:0] amt_m1;
    logic [W-1:0]  lo_fill, hi_fill, left_pre, right_pre;
    logic [XW-1:0] rot_x, rot_y;

    assign amt_m1    = amt - SW'(1);
    assign lo_fill   = ~({W{1'b1}} << amt);
    assign hi_fill   = ~({W{1'b1}} >> amt);
    // shifting one short exposes the last bit that leaves
    assign left_pre  = din << amt_m1;
    assign right_pre = din >> amt_m1;
    assign rot_x     = {cin, din};
    assign rot_y     = (rot_x >> amt) | (rot_x << (XW - int'(amt)));

    always_comb begin
        dout = din;
        cout = cin;
        if (amt != '0) begin
            unique case (mode)
                SH_ASR: begin
                    dout = $unsigned($signed(din) >>> amt);
                    cout = right_pre[0];
                end
                SH_LSL: begin
                    dout = din << amt;
                    cout = left_pre[W-1];
                end
                SH_CSL: begin
                    dout = (din << amt) | (cin ? lo_fill : '0);
                    cout = left_pre[W-1];
                end
                SH_LSR: begin
                    dout = din >> amt;
                    cout = right_pre[0];
                end
                SH_CSR: begin
                    dout = (din >> amt) | (cin ? hi_fill : '0);
                    cout = right_pre[0];
                end
                SH_ROR: begin
                    dout = (din >> amt) | (din << (W - int'(amt)));
                    cout = right_pre[0];
                end
                SH_CROR: begin
                    dout = rot_y[W-1:0];
                    cout = rot_y[W];
                end
                default: begin
                    dout = din;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/exec_seq.sv
module exec_seq
    import alu_shift_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd_need,
    input  logic wr_need,
    input  logic coll,
    output logic busy,
    output logic accept,
    output logic first,
    output logic last
);
    logic       busy_q;
    logic [1:0] ph_q;
    logic [1:0] len_q;

    assign busy   = busy_q;
    assign accept = start && !busy_q;
    assign first  = busy_q && (ph_q == 2'd1);
    assign last   = busy_q && (ph_q == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            len_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            ph_q   <= 2'd1;
            len_q  <= exec_cycles(rd_need, wr_need, coll);
        end else if (busy_q) begin
            if (ph_q == len_q) busy_q <= 1'b0;
            else               ph_q   <= ph_q + 2'd1;
        end
    end

    // R6: phase never runs past the length chosen at acceptance
    assert_phase_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (ph_q <= len_q) && (len_q != 2'd0));

    // R10: a start while busy does not restart the phase count
    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start && !last) |=> (ph_q == $past(ph_q) + 2'd1));

endmodule

// File: rtl/alu_shift_exec.sv
module alu_shift_exec
    import alu_shift_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [2:0]      shmode,
    input  logic [SAW-1:0]  shamt,
    input  logic            src_rem,
    input  logic            reg_wr,
    input  logic [1:0]      rdest,
    input  logic [AW-1:0]   rem_addr,
    input  logic [AW-1:0]   next_addr,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   result,
    output logic            flag_alu,
    output logic            flag_shift,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mem_ptr_only,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    instr_t         ins_d, ins_q;
    logic           accept, first, last;
    logic           rd_pend_q;
    logic [DW-1:0]  rdat_q;
    logic [DW-1:0]  a_eff, alu_res, sh_res;
    logic           c_alu, c_sh;
    logic [DW-1:0]  result_q;
    logic           fa_q, fs_q;

    assign ins_d = '{
        op:      alu_op_e'(op),
        mode:    shift_mode_e'(shmode),
        amt:     shamt,
        src_rem: src_rem,
        reg_wr:  reg_wr,
        rdest:   rdest_e'(rdest),
        raddr:   rem_addr,
        a:       opa,
        b:       opb
    };

    exec_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_need (src_rem),
        .wr_need (writes_remote(rdest_e'(rdest))),
        .coll    (rem_addr == next_addr),
        .busy    (busy),
        .accept  (accept),
        .first   (first),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q     <= '0;
            rd_pend_q <= 1'b0;
            rdat_q    <= '0;
        end else begin
            if (accept) ins_q <= ins_d;
            rd_pend_q <= mem_rd;
            if (rd_pend_q) rdat_q <= mem_rdata;
        end
    end

    // remote word is live the cycle after the read, held afterwards
    assign a_eff = ins_q.src_rem ? (rd_pend_q ? mem_rdata : rdat_q) : ins_q.a;

    alu_core #(.W(DW)) u_alu (
        .op   (ins_q.op),
        .a    (a_eff),
        .b    (ins_q.b),
        .cin  (fs_q),
        .res  (alu_res),
        .cout (c_alu)
    );

    shift_unit #(.W(DW), .SW(SAW)) u_shf (
        .mode (ins_q.mode),
        .amt  (ins_q.amt),
        .din  (alu_res),
        .cin  (c_alu),
        .dout (sh_res),
        .cout (c_sh)
    );

    assign done         = last;
    assign mem_addr     = ins_q.raddr;
    assign mem_rd       = first && ins_q.src_rem;
    assign mem_wr       = last && writes_remote(ins_q.rdest);
    assign mem_ptr_only = (ins_q.rdest == RD_PTR);
    assign mem_wdata    = sh_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            fa_q     <= 1'b0;
            fs_q     <= 1'b0;
        end else if (last) begin
            fa_q <= c_alu;
            fs_q <= c_sh;
            if (ins_q.reg_wr) result_q <= sh_res;
        end
    end

    assign result     = result_q;
    assign flag_alu   = fa_q;
    assign flag_shift = fs_q;

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: architectural state moves only on a completion edge
    assert_commit_only_on_done_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result) && $stable(flag_shift) && $stable(flag_alu));

    // R8: remote writes fall in the final cycle
    assert_write_in_final_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> done);

    // R7: the read never shares a cycle with completion
    assert_read_not_final_R7: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !done);

    // R4: a zero distance passes data and flag through the shifter
    assert_zero_shift_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && ins_q.amt == '0) |-> (sh_res == alu_res) && (c_sh == c_alu));

    // R2: logical operations leave the ALU flag clear
    assert_logic_clears_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (done && is_logic_op(ins_q.op)) |=> !flag_alu);

    // R11: idle after reset
    assert_reset_idle_R11: assert property (@(posedge clk)
        $past(rst) |-> !busy && !done);

endmodule

// File: tb/sim_alu_shift_exec.sv
module sim_alu_shift_exec;
    import alu_shift_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    logic        rst, start, src_rem, reg_wr;
    logic [2:0]  op, shmode;
    logic [4:0]  shamt;
    logic [1:0]  rdest;
    logic [8:0]  rem_addr, next_addr, mem_addr;
    logic [31:0] opa, opb, result, mem_wdata, mem_rdata;
    logic        busy, done, flag_alu, flag_shift, mem_rd, mem_wr, mem_ptr_only;

    alu_shift_exec u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .shmode(shmode), .shamt(shamt),
        .src_rem(src_rem), .reg_wr(reg_wr), .rdest(rdest), .rem_addr(rem_addr),
        .next_addr(next_addr), .opa(opa), .opb(opb), .busy(busy), .done(done),
        .result(result), .flag_alu(flag_alu), .flag_shift(flag_shift),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_ptr_only(mem_ptr_only), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [0:511];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) begin
            if (mem_ptr_only) mem[mem_addr][8:0] <= mem_wdata[8:0];
            else              mem[mem_addr]      <= mem_wdata;
        end
    end

    int n_run = 0;
    int n_fail = 0;

    // reference architectural state
    logic [31:0] m_res;
    logic        m_fa, m_fs;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_alu(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic cin, output logic [31:0] r, output logic c);
        logic [32:0] wide;
        longint unsigned need;
        case (o)
            3'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32]; end
            3'd1: begin wide = {1'b0, a} + {1'b0, b} + {32'd0, cin}; r = wide[31:0]; c = wide[32]; end
            3'd2: begin r = a - b; c = (a >= b); end
            3'd3: begin
                need = longint'(b) + (cin ? 0 : 1);
                r = a - b - {31'd0, ~cin};
                c = (longint'(a) >= need);
            end
            3'd4: begin r = a & b; c = 1'b0; end
            3'd5: begin r = a | b; c = 1'b0; end
            default: begin r = a ^ b; c = 1'b0; end
        endcase
    endtask

    task automatic m_shift(input logic [2:0] md, input logic [4:0] n, input logic [31:0] din,
                           input logic cin, output logic [31:0] r, output logic c);
        r = din;
        c = cin;
        for (int k = 0; k < int'(n); k++) begin
            logic o;
            case (md)
                3'd1: begin o = r[0];  r = {r[31], r[31:1]}; end
                3'd2: begin o = r[31]; r = {r[30:0], 1'b0}; end
                3'd3: begin o = r[31]; r = {r[30:0], cin}; end
                3'd4: begin o = r[0];  r = {1'b0, r[31:1]}; end
                3'd5: begin o = r[0];  r = {cin, r[31:1]}; end
                3'd6: begin o = r[0];  r = {r[0], r[31:1]}; end
                3'd7: begin o = r[0];  r = {c, r[31:1]}; end
                default: o = c;
            endcase
            c = o;
        end
    endtask

    task automatic run(input logic [2:0] o, input logic [2:0] md, input logic [4:0] n,
                       input logic srem, input logic rw, input logic [1:0] rd,
                       input logic [8:0] ra, input logic [8:0] na,
                       input logic [31:0] a, input logic [31:0] b, input bit hold);
        logic [31:0] a_eff, ar, sr, old_word, exp_word;
        logic        ac, sc;
        int          ncyc;
        bit          wr;
        wr = (rd == 2'b01) || (rd == 2'b10);
        ncyc = 1 + int'(srem) + int'(wr) + int'(ra == na);
        if (ncyc > 3) ncyc = 3;
        old_word = mem[ra];
        a_eff = srem ? old_word : a;
        m_alu(o, a_eff, b, m_fs, ar, ac);
        m_shift(md, n, ar, ac, sr, sc);
        exp_word = (rd == 2'b10) ? {old_word[31:9], sr[8:0]} : sr;

        @(negedge clk);
        op = o; shmode = md; shamt = n; src_rem = srem; reg_wr = rw; rdest = rd;
        rem_addr = ra; next_addr = na; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        for (int cyc = 1; cyc <= ncyc; cyc++) begin
            chk(busy == 1'b1, "R6 busy during execution", 32'(busy), 32'd1);
            chk(done == (cyc == ncyc), "R6/R9 done in final cycle only", 32'(done), 32'(cyc == ncyc));
            chk(mem_rd == (srem && cyc == 1), "R7 read strobe in cycle 1", 32'(mem_rd), 32'(srem && cyc == 1));
            chk(mem_wr == (wr && cyc == ncyc), "R8 write strobe in final cycle", 32'(mem_wr), 32'(wr && cyc == ncyc));
            if (srem && cyc == 1)
                chk(mem_addr == ra, "R7 read address", 32'(mem_addr), 32'(ra));
            if (wr && cyc == ncyc) begin
                chk(mem_addr == ra, "R8 write address", 32'(mem_addr), 32'(ra));
                chk(mem_wdata == sr, "R8 write data", mem_wdata, sr);
                chk(mem_ptr_only == (rd == 2'b10), "R8 pointer-only select", 32'(mem_ptr_only), 32'(rd == 2'b10));
            end
            if (cyc < ncyc) begin
                chk(result == m_res, "R9 result held before commit", result, m_res);
                chk(flag_shift == m_fs, "R9 flag held before commit", 32'(flag_shift), 32'(m_fs));
            end
            if (hold) begin
                // R10: scrambled inputs and a held start must not disturb the instruction
                opa = ~a; opb = ~b; op = ~o; rem_addr = ~ra;
                if (cyc == ncyc) start = 1'b0;
            end
            @(negedge clk);
        end
        if (rw) m_res = sr;
        m_fa = ac;
        m_fs = sc;
        chk(busy == 1'b0, "R6 idle after final cycle", 32'(busy), 32'd0);
        chk(result == m_res, "R1/R3/R9 result", result, m_res);
        chk(flag_alu == m_fa, "R2 ALU flag", 32'(flag_alu), 32'(m_fa));
        chk(flag_shift == m_fs, "R4 shift flag", 32'(flag_shift), 32'(m_fs));
        if (wr) chk(mem[ra] == exp_word, "R8 remote word content", mem[ra], exp_word);
    endtask

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0103);
        mem_rdata = '0;
        rst = 1'b1; start = 1'b0; op = '0; shmode = '0; shamt = '0; src_rem = 1'b0;
        reg_wr = 1'b0; rdest = '0; rem_addr = '0; next_addr = 9'd1; opa = '0; opb = '0;
        m_res = '0; m_fa = 1'b0; m_fs = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy after reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R11 done after reset", 32'(done), 32'd0);
        chk(result == 32'd0, "R11 result after reset", result, 32'd0);
        chk(flag_alu == 1'b0 && flag_shift == 1'b0, "R11 flags after reset", {30'd0, flag_alu, flag_shift}, 32'd0);

        // R1/R2: add, overflow, subtract with and without borrow
        run(3'd0, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'd100, 32'd23, 0);
        run(3'd0, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'hFFFF_FFF0, 32'h20, 0);
        // R5: add-with-carry consumes the committed shift flag (now 1)
        run(3'd1, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'd7, 32'd8, 0);
        run(3'd2, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'd50, 32'd8, 0);
        run(3'd2, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'd8, 32'd50, 0);
        // R5: subtract-with-borrow with flag clear, then with flag set
        run(3'd3, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'd20, 32'd5, 0);
        run(3'd3, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'd20, 32'd5, 0);
        // R2: logic ops clear the ALU flag
        run(3'd0, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'hFFFF_FFFF, 32'd1, 0);
        run(3'd4, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'hF0F0_1234, 32'h0FF0_FFFF, 0);
        run(3'd5, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'h8000_0001, 32'h0000_0F00, 0);
        run(3'd6, 3'd0, 5'd0, 0, 1, 2'b00, 9'd5, 9'd6, 32'hDEAD_BEEF, 32'hFFFF_0000, 0);

        // R3/R4: every mode at 0, 1, 5, 31, with the ALU flag set (ADD overflow) and clear (XOR)
        for (int md = 0; md < 8; md++) begin
            for (int s = 0; s < 4; s++) begin
                logic [4:0] n;
                n = (s == 0) ? 5'd0 : (s == 1) ? 5'd1 : (s == 2) ? 5'd5 : 5'd31;
                run(3'd0, 3'(md), n, 0, 1, 2'b00, 9'd5, 9'd6, 32'hC000_0003, 32'h4000_0001, 0);
                run(3'd6, 3'(md), n, 0, 1, 2'b00, 9'd5, 9'd6, 32'h9234_5679, 32'h0, 0);
            end
        end

        // R6/R7/R8: schedule combinations
        run(3'd0, 3'd2, 5'd3, 1, 1, 2'b00, 9'd40, 9'd41, 32'd0, 32'd9, 0);   // read: 2
        run(3'd0, 3'd0, 5'd0, 0, 0, 2'b01, 9'd41, 9'd42, 32'h1234, 32'd1, 0); // write full: 2
        mem[43] = 32'hFFFF_FFFF;
        run(3'd0, 3'd0, 5'd0, 0, 1, 2'b10, 9'd43, 9'd44, 32'h0000_0100, 32'd0, 0); // pointer write: 2
        run(3'd0, 3'd0, 5'd0, 0, 1, 2'b00, 9'd44, 9'd44, 32'd3, 32'd4, 0);  // collision: 2
        run(3'd2, 3'd4, 5'd2, 1, 1, 2'b01, 9'd45, 9'd46, 32'd0, 32'd1, 0);  // read+write: 3
        run(3'd0, 3'd0, 5'd0, 0, 1, 2'b01, 9'd47, 9'd47, 32'd77, 32'd1, 0); // write+collision: 3
        run(3'd0, 3'd0, 5'd0, 1, 1, 2'b00, 9'd48, 9'd48, 32'd0, 32'd2, 0);  // read+collision: 3
        run(3'd5, 3'd6, 5'd7, 1, 1, 2'b10, 9'd49, 9'd49, 32'd0, 32'h10, 0); // all three: 3
        // R9: no register write leaves result untouched
        run(3'd0, 3'd0, 5'd0, 0, 0, 2'b00, 9'd5, 9'd6, 32'hAAAA_0000, 32'd1, 0);
        // R10: start held and inputs scrambled while busy
        run(3'd0, 3'd3, 5'd4, 1, 1, 2'b01, 9'd50, 9'd51, 32'd0, 32'd11, 1);
        run(3'd6, 3'd5, 5'd9, 0, 1, 2'b00, 9'd52, 9'd53, 32'h7777_0000, 32'h0F0F_0F0F, 1);

        // mixed stream over all fields
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r0, r1, r2;
            logic [1:0]  rd;
            r0 = $urandom; r1 = $urandom; r2 = $urandom;
            rd = (r0[1:0] == 2'b11) ? 2'b00 : r0[1:0];
            run(3'(r0[4:2] % 3'd7), r0[7:5], r0[12:8], r0[13], r0[14], rd,
                9'(r0[19:16]), (r0[21:20] == 2'b00) ? 9'(r0[19:16]) : 9'(r0[19:16]) + 9'd1,
                r1, r2, r0[22] && r0[23]);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule